// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a byte-wide flash device. It decides whether a program or erase operation inside the device has finished. After a `start` pulse it issues byte reads through a plain request/acknowledge read port. Every read goes to one captured verify address, which may be any value when a whole-chip erase is being watched. The block takes the status bits from each pair of reads. If bit 6 reads the same in both reads of a pair, the operation is over. If bit 6 differs, the operation is still running, and bit 5 shows whether the device has flagged an internal timeout.

When the timeout flag is seen together with a toggling bit 6, the poller does not declare failure at once. It takes one more pair of reads, because the toggling can stop at the very moment the flag rises. An optional ceiling on the number of reads turns an endless toggle into a fail, so a dead device cannot stall the host. The result appears as a one-cycle `done` strobe with a `pass` or `fail` flag. The flag stays set until the next accepted start.

Top module: `togpoll_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `pass_o` and `fail_o` are all 0.
- R2: A start accepted while idle captures `addr_i`, and every read request until the following `done_o` presents that address on `rd_addr_o`.
- R3: Once raised, `rd_req_o` stays high until a cycle with `rd_ack_i` high. Read data is taken only in that acknowledge cycle, and the request falls on the next edge.
- R4: Each check uses two reads: the first gives a reference value of data bit 6 and the second is compared against it. If bit 6 is equal in both reads, the poll ends with pass.
- R5: If bit 6 differs and data bit 5 of the second read is 0, a new two-read check begins.
- R6: If bit 6 differs and data bit 5 of the second read is 1, exactly two more reads follow. The poll ends with pass if bit 6 is equal in them and with fail if it differs.
- R7: With `MAX_READS` nonzero, a toggling compare with bit 5 at 0, taken when `MAX_READS` or more reads have been issued, ends the poll with fail.
- R8: `start_i` has no effect while a poll is in progress: the address, the read sequence and the result are unchanged.
- R9: `done_o` is high for exactly one cycle per poll. Exactly one of `pass_o` and `fail_o` is set with it, and that flag holds until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (taken only when idle) |
| addr_i | input | ADDR_W | Verify address (any value for chip erase) |
| rd_req_o | output | 1 | Read request to the device |
| rd_addr_o | output | ADDR_W | Address of the requested read |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | 8 | Byte returned by the device |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation reported timeout or read ceiling hit |

## Verification
The two behaviours that can coincide are the timeout flag (bit 5) rising and bit 6 ceasing to toggle. Both can show up across the same pair of reads. The bench's device model sets the read index at which toggling stops and the index at which bit 5 rises independently. Directed cases put these on the same read and on neighbouring reads. A bench function walks the two-read rule over that scripted sequence to predict pass or fail and the exact number of reads. A premature fail on the coincident read, or a missing confirmation pair, shows up as a wrong verdict or a wrong read count.

// File: rtl/togpoll_pkg.sv
package togpoll_pkg;
  localparam int DATA_W  = 8;
  localparam int TOG_POS = 6;
  localparam int TMO_POS = 5;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_REF,
    PS_CMP,
    PS_REF2,
    PS_CMP2
  } poll_state_e;
endpackage

// File: rtl/togpoll_rdport.sv
module togpoll_rdport
  import togpoll_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              ack,
  input  logic [DATA_W-1:0] data_in,
  output logic              req,
  output logic              got,
  output logic              tog_bit,
  output logic              tmo_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= 1'b0;
      got     <= 1'b0;
      tog_bit <= 1'b0;
      tmo_bit <= 1'b0;
    end else begin
      got <= 1'b0;
      if (issue) begin
        req <= 1'b1;
      end else if (req && ack) begin
        req     <= 1'b0;
        got     <= 1'b1;
        tog_bit <= data_in[TOG_POS];
        tmo_bit <= data_in[TMO_POS];
      end
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  assert_req_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> (!req && got));
endmodule

// File: rtl/togpoll_limit.sv
module togpoll_limit #(
  parameter int MAX_READS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CNT_W = $clog2(MAX_READS + 4);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  generate
    if (MAX_READS == 0) begin : g_off
      assign hit = 1'b0;
    end else begin : g_on
      assign hit = (cnt >= CNT_W'(MAX_READS));
      assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_READS + 2));
    end
  endgenerate
endmodule

// File: rtl/togpoll_fsm.sv
module togpoll_fsm
  import togpoll_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              got,
  input  logic              tog_bit,
  input  logic              tmo_bit,
  input  logic              limit_hit,
  output logic              issue,
  output logic              cnt_clr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  poll_state_e st;
  logic        ref_bit;

  assign cnt_clr = (st == PS_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PS_IDLE;
      issue   <= 1'b0;
      ref_bit <= 1'b0;
      addr_q  <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      issue <= 1'b0;
      done  <= 1'b0;
      case (st)
        PS_IDLE: if (start) begin
          addr_q <= addr_in;
          pass   <= 1'b0;
          fail   <= 1'b0;
          issue  <= 1'b1;
          st     <= PS_REF;
        end
        PS_REF, PS_REF2: if (got) begin
          ref_bit <= tog_bit;
          issue   <= 1'b1;
          st      <= (st == PS_REF) ? PS_CMP : PS_CMP2;
        end
        PS_CMP: if (got) begin
          if (tog_bit == ref_bit) begin
            done <= 1'b1; pass <= 1'b1; st <= PS_IDLE;
          end else if (tmo_bit) begin
            issue <= 1'b1; st <= PS_REF2;
          end else if (limit_hit) begin
            done <= 1'b1; fail <= 1'b1; st <= PS_IDLE;
          end else begin
            issue <= 1'b1; st <= PS_REF;
          end
        end
        PS_CMP2: if (got) begin
          done <= 1'b1;
          pass <= (tog_bit == ref_bit);
          fail <= (tog_bit != ref_bit);
          st   <= PS_IDLE;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_verdict_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));
  assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st == PS_IDLE && !start) |=> ($stable(pass) && $stable(fail)));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (st != PS_IDLE) |=> $stable(addr_q));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == PS_IDLE && !issue));
endmodule

// File: rtl/togpoll_ctrl.sv
module togpoll_ctrl
  import togpoll_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_READS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << TOG_POS) | (1 << TMO_POS));

  logic issue, got, tog_bit, tmo_bit, limit_hit, cnt_clr;
  logic unused_bits;

  assign unused_bits = ^(rd_data_i & ~USED_MASK);

  togpoll_rdport u_rdport (
    .clk(clk), .rst(rst), .issue(issue), .ack(rd_ack_i), .data_in(rd_data_i),
    .req(rd_req_o), .got(got), .tog_bit(tog_bit), .tmo_bit(tmo_bit)
  );

  togpoll_limit #(.MAX_READS(MAX_READS)) u_limit (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(issue), .hit(limit_hit)
  );

  togpoll_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start_i), .addr_in(addr_i), .got(got),
    .tog_bit(tog_bit), .tmo_bit(tmo_bit), .limit_hit(limit_hit),
    .issue(issue), .cnt_clr(cnt_clr), .addr_q(rd_addr_o),
    .done(done_o), .pass(pass_o), .fail(fail_o)
  );
endmodule

// File: tb/togpoll_ctrl_bench.sv
module togpoll_ctrl_bench;
  localparam int AW  = 16;
  localparam int MAX = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic rd_req_o, rd_ack_i, done_o, pass_o, fail_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0] rd_data_i;

  int n_chk = 0, n_bad = 0;
  int tog_end = 0, tmo_at = 0, idx = 0, dly = 0, addr_err = 0;
  logic [AW-1:0] cur_addr = '0;

  always #2.5 clk = ~clk;

  togpoll_ctrl #(.ADDR_W(AW), .MAX_READS(MAX)) u_togpoll_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  function automatic logic b6(int j);
    if (j < tog_end) return j[0];
    if (tog_end == 0) return 1'b0;
    return 1'(tog_end - 1);
  endfunction

  task automatic predict(output logic ok, output int nr);
    int i = 0;
    logic r, c;
    forever begin
      r = b6(i); i++; c = b6(i);
      if (c == r) begin ok = 1'b1; nr = i + 1; return; end
      if (i >= tmo_at) begin
        i++; r = b6(i); i++; c = b6(i);
        ok = (c == r); nr = i + 1; return;
      end
      i++;
      if (i >= MAX) begin ok = 1'b0; nr = i; return; end
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model: answers requests after a random delay
  always @(negedge clk) begin
    if (rst) begin
      rd_ack_i <= 1'b0; rd_data_i <= '0;
    end else if (rd_ack_i) begin
      rd_ack_i <= 1'b0; idx <= idx + 1;
    end else if (rd_req_o) begin
      if (rd_addr_o !== cur_addr) addr_err <= addr_err + 1;
      if (dly == 0) begin
        rd_ack_i  <= 1'b1;
        rd_data_i <= {1'b0, b6(idx), (idx >= tmo_at), 5'($urandom)} ^ 8'h80;
        dly       <= $urandom % 3;
      end else dly <= dly - 1;
    end
  end

  task automatic run(int t, int k, logic [AW-1:0] a, bit poke);
    logic ok; int nr, w;
    tog_end = t; tmo_at = k; idx = 0; addr_err = 0; cur_addr = a;
    predict(ok, nr);
    @(negedge clk); addr_i = a; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; addr_i = ~a;
    check("R9 flags cleared at start", {pass_o, fail_o}, 2'b00);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0; // R8 ignored while busy
    end
    w = 0;
    while (!done_o && w < 3000) begin @(negedge clk); w++; end
    check("R9 done seen", done_o, 1'b1);
    check(ok ? "R4/R6 pass verdict" : "R6/R7 fail verdict", {pass_o, fail_o}, ok ? 2'b10 : 2'b01);
    check("R5/R6/R7 read count", idx, nr);
    check(poke ? "R8 address kept" : "R2 address", addr_err, 0);
    @(negedge clk);
    check("R9 done one cycle", done_o, 1'b0);
    check("R9 verdict held", {pass_o, fail_o, rd_req_o}, ok ? 3'b100 : 3'b010);
  endtask

  initial begin
    #150000ns;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 reset state", {rd_req_o, done_o, pass_o, fail_o}, 4'b0);
    rst = 1'b0;
    @(negedge clk);
    run(0, 99, 16'h1234, 0);     // R4 already stable: two reads
    run(5, 99, 16'h00ff, 0);     // R5 several passes
    run(1000, 1, 16'hbeef, 0);   // R6 still toggling -> fail
    run(2, 1, 16'h0001, 0);      // R6 stop coincides with bit 5 rising -> pass
    run(3, 1, 16'h0002, 0);      // R6 stops during confirmation pair
    run(4, 3, 16'h0003, 0);      // R6 bit 5 and stop on same read
    run(1000, 1000, 16'h4444, 0);// R7 read ceiling
    run(12, 99, 16'hcafe, 1);    // R8 start while busy
    for (int s = 0; s < 30; s++)
      run($urandom % 24, $urandom % 28, 16'($urandom), ($urandom % 4) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule